// File: doc/BRIEF.md
# Multi-Client Poll Retry Sequencer

This block runs the host side of one multi-client poll exchange in a wireless MAC. When a poll is requested it works out the set of clients to address and predicts the air time of the full exchange: command frame, reply slots and acknowledge tail. It then compares that prediction with the command window that is still left. If the window is large enough it starts the command transmission, times the transmit phase, and opens a reply window sized to the number of addressed clients. While that window is open, per-client reply strobes clear the clients that answered.

When the reply window closes, the block reports a completion word. If every addressed client answered, the transaction ends. If some did not, the block immediately starts a new attempt addressed only to the clients that are still silent. Each new attempt passes through the same window check. If the prediction no longer fits, the transaction is abandoned with the failure word. One time unit equals one clock cycle.

Top module: `mp_poll_retry_seq`

## Requirements
- R1: After reset busy_o, pending_o, tx_start_o, done_o, irq_word_o and irq_done_o are low and phase_o is 0 (idle).
- R2: Client bit 0 is never addressed. The first attempt of a new transaction addresses req_mask_i with bit 0 forced to zero, and active_mask_o shows that value in the cycle tx_start_o is high.
- R3: A retry attempt addresses exactly the clients of the previous attempt that did not reply.
- R4: An attempt starts (tx_start_o high for one cycle) only if window_i > D + 100. D = preamble + len×k + 112 + (10 + reply_time)×n + 32×k, where k = 4 and preamble = 96 for rate code 0x14, k = 8 and preamble = 192 for any other code, and n = number of set bits in the active mask.
- R5: If the window check fails, done_o pulses with code 0x0005 and irq_done_o stays low. Busy and pending are low one cycle later.
- R6: The transmit phase (phase_o = 2) lasts preamble + len×k cycles.
- R7: The reply phase (phase_o = 3) lasts 112 + (10 + reply_time)×n cycles, which is 112 when n = 0.
- R8: A bit of reply_bits_i clears that client's failure flag only while phase_o = 3. Replies at any other time have no effect.
- R9: At the end of each reply phase (phase_o = 4) done_o and irq_word_o pulse. done_code_o is 0x0001 if no addressed client is left unanswered and 0x0005 otherwise.
- R10: After a 0x0005 report at phase 4, busy_o and pending_o stay high, and the next attempt's check is made in the following cycle.
- R11: After a 0x0001 report, irq_done_o pulses in the same cycle. In the next cycle busy_o and pending_o are low and phase_o is 0.
- R12: start_i is ignored while a transaction is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a new poll transaction (idle only) |
| rate_code_i | input | 8 | Rate code; 0x14 selects fast rate |
| frame_len_i | input | 12 | Command frame length in bytes |
| req_mask_i | input | 16 | Requested client bitmask |
| reply_time_i | input | 8 | Per-client reply slot extension |
| reply_bits_i | input | 16 | Per-client reply received strobes |
| window_i | input | 32 | Remaining command window, in time units |
| tx_start_o | output | 1 | Command transmission starts (one cycle) |
| busy_o | output | 1 | Transaction in progress |
| pending_o | output | 1 | Command slot pending flag |
| phase_o | output | 3 | 0 idle, 1 check, 2 transmit, 3 reply wait, 4 report |
| active_mask_o | output | 16 | Clients addressed by the current attempt |
| done_o | output | 1 | Completion word valid (one cycle) |
| done_code_o | output | 16 | 0x0001 all replied, 0x0005 failure |
| irq_word_o | output | 1 | Completion word interrupt at end of a reply phase |
| irq_done_o | output | 1 | Transaction completed successfully |

## Verification
A corrupted failure mask shows up as a wrong done_code_o when the current reply phase closes. It also shows up in the cycle after, as a wrong active_mask_o at the next tx_start_o. A miscounted client number or timer load shifts phase_o transitions, and this is visible as a wrong cycle count for phase 2 or 3 within one attempt. Off-by-one errors in the window comparison appear as a tx_start_o where an abort was due, or the reverse. These appear in the cycle right after the request or the report.

// File: rtl/mp_poll_retry_pkg.sv
// Shared constants and phase encoding for the poll retry sequencer.
package mp_poll_retry_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_CHECK = 3'd1,
        PH_TX    = 3'd2,
        PH_WAIT  = 3'd3,
        PH_EVAL  = 3'd4
    } phase_e;

    localparam logic [7:0]  FAST_RATE_CODE = 8'h14;
    localparam logic [15:0] CODE_OK        = 16'h0001;
    localparam logic [15:0] CODE_FAIL      = 16'h0005;
    localparam logic [15:0] FAIL_INIT      = 16'hFFFE;
    localparam int          ACK_BASE       = 112;
    localparam int          SLOT_BASE      = 10;
    localparam int          TAIL_BYTES     = 32;
    localparam int          WINDOW_MARGIN  = 100;

endpackage

// File: rtl/mpr_popcount.sv
// Counts set bits of a vector with a ripple adder chain.
// Assumes: CW is wide enough to hold W.
module mpr_popcount #(
    parameter int W  = 16,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  bits_i,
    output logic [CW-1:0] count_o
);
    logic [CW-1:0] part [W+1];

    assign part[0] = '0;
    for (genvar g = 0; g < W; g++) begin : g_add
        assign part[g+1] = part[g] + CW'(bits_i[g]);
    end
    assign count_o = part[W];
endmodule

// File: rtl/mpr_duration.sv
// Computes transmit-phase, reply-phase and full-exchange durations.
// Assumes: TW bits hold the largest total for the given widths.
module mpr_duration
    import mp_poll_retry_pkg::*;
#(
    parameter int LW       = 12,
    parameter int RW       = 8,
    parameter int CW       = 5,
    parameter int TW       = 20,
    parameter int PRE_FAST = 96,
    parameter int PRE_SLOW = 192
) (
    input  logic          fast_i,
    input  logic [LW-1:0] len_i,
    input  logic [RW-1:0] rtime_i,
    input  logic [CW-1:0] clients_i,
    output logic [TW-1:0] tx_units_o,
    output logic [TW-1:0] wait_units_o,
    output logic [TW-1:0] total_units_o
);
    logic [TW-1:0] len_scaled, per_client, tail;

    // byte time scaling and reply slot cost
    always_comb begin
        len_scaled    = fast_i ? (TW'(len_i) << 2) : (TW'(len_i) << 3);
        tail          = fast_i ? TW'(TAIL_BYTES * 4) : TW'(TAIL_BYTES * 8);
        per_client    = TW'(SLOT_BASE) + TW'(rtime_i);
        tx_units_o    = (fast_i ? TW'(PRE_FAST) : TW'(PRE_SLOW)) + len_scaled;
        wait_units_o  = TW'(ACK_BASE) + per_client * TW'(clients_i);
        total_units_o = tx_units_o + wait_units_o + tail;
    end
endmodule

// File: rtl/mpr_phase_timer.sv
// Down-counter timing one phase; expire_o is high in the last cycle.
// Assumes: load values are at least 1.
module mpr_phase_timer #(
    parameter int TW = 20
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [TW-1:0] value_i,
    input  logic          run_i,
    output logic          expire_o
);
    logic [TW-1:0] cnt_q;

    // load or count down while the phase runs
    always_ff @(posedge clk_i) begin
        if (!rst_ni)       cnt_q <= '0;
        else if (load_i)   cnt_q <= value_i;
        else if (run_i && cnt_q != '0) cnt_q <= cnt_q - TW'(1);
    end

    assign expire_o = run_i && (cnt_q == TW'(1));
endmodule

// File: rtl/mp_poll_retry_seq.sv
// Host-side poll sequencer: window check, transmit, reply wait, report,
// and retry addressed only to silent clients.
// Assumes: one time unit per clock; window_i is maintained outside.
module mp_poll_retry_seq
    import mp_poll_retry_pkg::*;
#(
    parameter int NC       = 16,
    parameter int LW       = 12,
    parameter int RW       = 8,
    parameter int WW       = 32,
    parameter int TW       = 20,
    parameter int PRE_FAST = 96,
    parameter int PRE_SLOW = 192
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [7:0]    rate_code_i,
    input  logic [LW-1:0] frame_len_i,
    input  logic [NC-1:0] req_mask_i,
    input  logic [RW-1:0] reply_time_i,
    input  logic [NC-1:0] reply_bits_i,
    input  logic [WW-1:0] window_i,
    output logic          tx_start_o,
    output logic          busy_o,
    output logic          pending_o,
    output logic [2:0]    phase_o,
    output logic [NC-1:0] active_mask_o,
    output logic          done_o,
    output logic [15:0]   done_code_o,
    output logic          irq_word_o,
    output logic          irq_done_o
);
    localparam int CW = $clog2(NC + 1);
    localparam logic [NC-1:0] FAIL_SEED = NC'(FAIL_INIT);

    phase_e        state_q, state_d;
    logic [NC-1:0] req_q, fail_q, act_q, act_sel;
    logic          fast_q, pend_q;
    logic [LW-1:0] len_q;
    logic [RW-1:0] rt_q;
    logic [CW-1:0] n_clients;
    logic [TW-1:0] tx_units, wait_units, total_units;
    logic          win_ok, expire, tmr_load;
    logic [TW-1:0] tmr_value;

    // clients of this attempt: narrowed in the check phase, held otherwise
    assign act_sel = (state_q == PH_CHECK) ? (req_q & fail_q) : act_q;

    mpr_popcount #(.W(NC), .CW(CW)) u_count (
        .bits_i  (act_sel),
        .count_o (n_clients)
    );

    mpr_duration #(
        .LW(LW), .RW(RW), .CW(CW), .TW(TW),
        .PRE_FAST(PRE_FAST), .PRE_SLOW(PRE_SLOW)
    ) u_dur (
        .fast_i        (fast_q),
        .len_i         (len_q),
        .rtime_i       (rt_q),
        .clients_i     (n_clients),
        .tx_units_o    (tx_units),
        .wait_units_o  (wait_units),
        .total_units_o (total_units)
    );

    // window must exceed predicted duration plus margin
    assign win_ok = window_i > (WW'(total_units) + WW'(WINDOW_MARGIN));

    // timer loads on attempt start and on transmit end
    always_comb begin
        tmr_load  = 1'b0;
        tmr_value = tx_units;
        if (state_q == PH_CHECK && win_ok) begin
            tmr_load  = 1'b1;
            tmr_value = tx_units;
        end else if (state_q == PH_TX && expire) begin
            tmr_load  = 1'b1;
            tmr_value = wait_units;
        end
    end

    mpr_phase_timer #(.TW(TW)) u_tmr (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (tmr_load),
        .value_i  (tmr_value),
        .run_i    (state_q == PH_TX || state_q == PH_WAIT),
        .expire_o (expire)
    );

    // next phase selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE:  if (start_i) state_d = PH_CHECK;
            PH_CHECK: state_d = win_ok ? PH_TX : PH_IDLE;
            PH_TX:    if (expire) state_d = PH_WAIT;
            PH_WAIT:  if (expire) state_d = PH_EVAL;
            PH_EVAL:  state_d = (fail_q == '0) ? PH_IDLE : PH_CHECK;
            default:  state_d = PH_IDLE;
        endcase
    end

    // phase register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= PH_IDLE;
        else         state_q <= state_d;
    end

    // transaction parameters latched on a new request
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            req_q  <= '0;
            fast_q <= 1'b0;
            len_q  <= '0;
            rt_q   <= '0;
        end else if (state_q == PH_IDLE && start_i) begin
            req_q  <= req_mask_i;
            fast_q <= (rate_code_i == FAST_RATE_CODE);
            len_q  <= frame_len_i;
            rt_q   <= reply_time_i;
        end
    end

    // failure and active masks
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            fail_q <= '0;
            act_q  <= '0;
        end else begin
            unique case (state_q)
                PH_IDLE:  if (start_i) fail_q <= FAIL_SEED;
                PH_CHECK: begin
                    fail_q <= act_sel;
                    act_q  <= act_sel;
                end
                PH_WAIT:  fail_q <= fail_q & ~reply_bits_i;
                default:  ;
            endcase
        end
    end

    // slot pending flag: set on request, cleared on success or abort
    always_ff @(posedge clk_i) begin
        if (!rst_ni) pend_q <= 1'b0;
        else if (state_q == PH_IDLE && start_i) pend_q <= 1'b1;
        else if (state_q == PH_CHECK && !win_ok) pend_q <= 1'b0;
        else if (state_q == PH_EVAL && fail_q == '0) pend_q <= 1'b0;
    end

    // output strobes and status
    always_comb begin
        tx_start_o  = (state_q == PH_CHECK) && win_ok;
        irq_word_o  = (state_q == PH_EVAL);
        irq_done_o  = (state_q == PH_EVAL) && (fail_q == '0);
        done_o      = irq_word_o || ((state_q == PH_CHECK) && !win_ok);
        done_code_o = irq_done_o ? CODE_OK : (done_o ? CODE_FAIL : 16'h0000);
    end

    assign busy_o        = (state_q != PH_IDLE);
    assign pending_o     = pend_q;
    assign phase_o       = state_q;
    assign active_mask_o = act_sel;
endmodule

// File: rtl/mp_poll_retry_seq_chk.sv
// Port-level protocol checks for the poll retry sequencer.
module mp_poll_retry_seq_chk #(
    parameter int NC = 16
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          tx_start_o,
    input logic          done_o,
    input logic [15:0]   done_code_o,
    input logic          irq_word_o,
    input logic          irq_done_o,
    input logic          busy_o,
    input logic          pending_o,
    input logic [NC-1:0] active_mask_o
);
    assert_no_bit0_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_start_o |-> !active_mask_o[0]);

    assert_retry_narrows_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_start_o && $past(irq_word_o)) |-> ((active_mask_o & ~$past(active_mask_o)) == '0));

    assert_start_or_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({tx_start_o, done_o}));

    assert_code_legal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (done_code_o == 16'h0001 || done_code_o == 16'h0005));

    assert_retry_keeps_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_word_o && !irq_done_o) |=> (busy_o && pending_o));

    assert_busy_release_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> $past(done_o));
endmodule

bind mp_poll_retry_seq mp_poll_retry_seq_chk #(.NC(NC)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tx_start_o    (tx_start_o),
    .done_o        (done_o),
    .done_code_o   (done_code_o),
    .irq_word_o    (irq_word_o),
    .irq_done_o    (irq_done_o),
    .busy_o        (busy_o),
    .pending_o     (pending_o),
    .active_mask_o (active_mask_o)
);

// File: tb/mp_poll_retry_seq_test.sv
// Directed bench for the poll retry sequencer.
module mp_poll_retry_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  rate = 8'h14;
    logic [11:0] len = '0;
    logic [15:0] req = '0;
    logic [7:0]  rt = '0;
    logic [15:0] rep = '0;
    logic [31:0] win = 32'h000F_FFFF;
    logic        tx_start, busy, pending, done, irq_word, irq_done;
    logic [2:0]  phase;
    logic [15:0] act, code;
    int          n_chk = 0, n_fail = 0, cyc = 0;

    always #10 clk = ~clk;

    mp_poll_retry_seq uut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rate_code_i(rate),
        .frame_len_i(len), .req_mask_i(req), .reply_time_i(rt),
        .reply_bits_i(rep), .window_i(win), .tx_start_o(tx_start),
        .busy_o(busy), .pending_o(pending), .phase_o(phase),
        .active_mask_o(act), .done_o(done), .done_code_o(code),
        .irq_word_o(irq_word), .irq_done_o(irq_done)
    );

    task automatic chk(input bit ok, input string req_tag, input int actual, input int expected);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req_tag, actual, expected);
        end
    endtask

    function automatic int tx_u(input bit f, input int l);
        return (f ? 96 : 192) + l * (f ? 4 : 8);
    endfunction
    function automatic int wait_u(input int r, input int n);
        return 112 + (10 + r) * n;
    endfunction
    function automatic int dur(input bit f, input int l, input int r, input int n);
        return tx_u(f, l) + wait_u(r, n) + 32 * (f ? 4 : 8);
    endfunction

    task automatic kick(input [7:0] rc, input [11:0] l, input [15:0] m, input [7:0] r);
        @(negedge clk);
        rate = rc; len = l; req = m; rt = r; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // one attempt: check start, phase lengths, report; ends at the report cycle
    task automatic attempt(input [15:0] exp_act, input int exp_tx, input int exp_wt,
                           input [15:0] tx_rep, input [15:0] wt_rep,
                           input [31:0] wt_win, input [15:0] exp_code);
        int ntx = 0, nwt = 0;
        chk(tx_start == 1'b1, "R4 attempt start", tx_start, 1);
        chk(act == exp_act, "R2/R3 active mask", act, exp_act);
        @(negedge clk);
        while (phase == 3'd2 && ntx < 5000) begin
            rep = (ntx == 0) ? tx_rep : 16'h0;
            if (ntx == 1) start = 1'b1; else start = 1'b0;
            ntx++;
            @(negedge clk);
        end
        rep = '0; start = 1'b0;
        chk(ntx == exp_tx, "R6 transmit length", ntx, exp_tx);
        while (phase == 3'd3 && nwt < 5000) begin
            rep = (nwt == 0) ? wt_rep : 16'h0;
            if (nwt == 0 && wt_win != 0) win = wt_win;
            nwt++;
            @(negedge clk);
        end
        rep = '0;
        chk(nwt == exp_wt, "R7 reply length", nwt, exp_wt);
        chk(done && irq_word && code == exp_code, "R9 report code", code, exp_code);
        chk(irq_done == (exp_code == 16'h0001), "R9/R11 completion irq", irq_done, exp_code == 16'h0001);
    endtask

    task automatic expect_idle(input string tag);
        @(negedge clk);
        chk(!busy && !pending && phase == 3'd0, tag, {busy, pending, phase}, 0);
    endtask

    task automatic t_reset;
        chk(!busy && !pending && !tx_start && !done && !irq_word && !irq_done && phase == 0,
            "R1 reset state", {busy, pending, tx_start, done, phase}, 0);
    endtask

    task automatic t_single_fast;
        kick(8'h14, 12'd4, 16'h0006, 8'd2);
        attempt(16'h0006, tx_u(1, 4), wait_u(2, 2), 16'h0, 16'h0006, 0, 16'h0001);
        expect_idle("R11 release after success");
    endtask

    task automatic t_bit0;
        kick(8'h14, 12'd2, 16'h0003, 8'd0);
        attempt(16'h0002, tx_u(1, 2), wait_u(0, 1), 16'h0, 16'h0003, 0, 16'h0001);
        expect_idle("R2 bit0 transaction ends");
    endtask

    task automatic t_retry;
        kick(8'h14, 12'd3, 16'h000E, 8'd1);
        attempt(16'h000E, tx_u(1, 3), wait_u(1, 3), 16'h0, 16'h000A, 0, 16'h0005);
        @(negedge clk);
        chk(busy && pending, "R10 busy kept on retry", {busy, pending}, 3);
        attempt(16'h0004, tx_u(1, 3), wait_u(1, 1), 16'h0, 16'h0004, 0, 16'h0001);
        expect_idle("R11 release after retry success");
    endtask

    task automatic t_window;
        int d = dur(0, 3, 1, 1);
        win = d + 100;
        kick(8'h0A, 12'd3, 16'h0002, 8'd1);
        chk(!tx_start && done && code == 16'h0005, "R4/R5 abort at D+100", code, 5);
        chk(!irq_done, "R5 no completion irq", irq_done, 0);
        expect_idle("R5 release after abort");
        win = d + 101;
        kick(8'h0A, 12'd3, 16'h0002, 8'd1);
        attempt(16'h0002, tx_u(0, 3), wait_u(1, 1), 16'h0, 16'h0002, 0, 16'h0001);
        expect_idle("R4 D+101 completes");
        win = 32'h000F_FFFF;
    endtask

    task automatic t_retry_abort;
        kick(8'h14, 12'd1, 16'h0006, 8'd0);
        attempt(16'h0006, tx_u(1, 1), wait_u(0, 2), 16'h0, 16'h0004, 32'd50, 16'h0005);
        @(negedge clk);
        chk(!tx_start && done && code == 16'h0005 && act == 16'h0002,
            "R5 retry aborted by window", code, 5);
        expect_idle("R5 release after retry abort");
        win = 32'h000F_FFFF;
    endtask

    task automatic t_ignore;
        // reply during transmit and start while busy must not matter
        kick(8'h14, 12'd2, 16'h0002, 8'd3);
        attempt(16'h0002, tx_u(1, 2), wait_u(3, 1), 16'h0002, 16'h0, 0, 16'h0005);
        @(negedge clk);
        chk(tx_start && act == 16'h0002, "R8 early reply ignored", act, 2);
        chk(len == 12'd2, "R12 bench sanity", len, 2);
        attempt(16'h0002, tx_u(1, 2), wait_u(3, 1), 16'h0, 16'h0002, 0, 16'h0001);
        expect_idle("R12 start while busy ignored");
    endtask

    task automatic t_empty;
        kick(8'h14, 12'd0, 16'h0001, 8'd5);
        attempt(16'h0000, tx_u(1, 0), wait_u(5, 0), 16'h0, 16'h0, 0, 16'h0001);
        expect_idle("R7 empty mask completes");
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_single_fast();
        t_bit0();
        t_retry();
        t_window();
        t_retry_abort();
        t_ignore();
        t_empty();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule